// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block brings an SDRAM or DDR SDRAM device from power-up to its operating state. After a one-cycle start request it walks a fixed list of commands (precharge-all, mode writes and auto refreshes) and drives them onto a command, bank and address output. Between commands it drives NOP, and it holds a long settling wait that lasts 200 microseconds, counted in clocks from the programmed clock frequency in MHz. When the last mode write has gone out it raises a done flag that lets the surrounding controller start periodic refresh.

The command list depends on the memory type. A DDR part first gets a precharge-all, then an extended mode write that turns the DLL on at normal drive strength, then a mode write that resets the DLL. After the settling wait both types get a precharge-all, two auto refreshes and a final mode write in normal operating mode. The mode word always selects burst length 8 with sequential bursts, and the CAS latency is 2.5 or 2. The block also turns a 3-bit refresh period code and the clock frequency into the refresh interval value used by the refresh timer.

Top module: `dinit_seq`

## Requirements
- R1: Command codes are NOP=0, PRECHARGE=1, MODE WRITE=2, AUTO REFRESH=3. After reset `cmd` is NOP and `busy` and `init_done` are low.
- R2: For DDR the commands are, in order: PRECHARGE with addr bit 10 set; MODE WRITE to bank 1 with addr 0; MODE WRITE to bank 0 with the base mode word plus addr bit 8 (DLL reset) set; PRECHARGE with addr bit 10 set; AUTO REFRESH; AUTO REFRESH; MODE WRITE to bank 0 with the base mode word. Bank is 0 and addr is 0 except where stated.
- R3: For SDR the commands are PRECHARGE (addr bit 10 set), AUTO REFRESH, AUTO REFRESH and MODE WRITE to bank 0 with the base mode word. The PRECHARGE appears max(200×MHz, MIN_GAP) cycles after the first cycle following the start edge.
- R4: The base mode word has addr[2:0]=3'b011 (burst 8), addr[3]=0 (sequential), and addr[6:4]=3'b110 when `cl_half` is set (CL 2.5) or 3'b010 otherwise (CL 2). All other bits are zero.
- R5: For DDR the first command appears in the cycle right after the start edge. Consecutive commands are exactly MIN_GAP cycles apart, and every cycle in between carries NOP.
- R6: For DDR the gap between the DLL-reset mode write and the next PRECHARGE is max(200×MHz, MIN_GAP) cycles.
- R7: `busy` is high from the cycle after an accepted start through the final mode write. `init_done` rises in the following cycle and stays high until the next accepted start. `cmd` is NOP whenever `busy` is low, and `busy` and `init_done` are never both high.
- R8: A start request while `busy` is high is ignored. The configuration inputs are sampled on each cycle while not busy and are held while busy, so changes to them during the sequence have no effect on it.
- R9: `ref_sel` selects a refresh period of 15625, 3900, 7800, 31300, 62500 or 125000 ns for codes 0 to 5. Codes 6 and 7 select 125000 ns.
- R10: `ref_interval` = floor(period_ns × MHz / 64000) − 1, saturating at 0. It follows the inputs one cycle later while not busy and stays frozen while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the power-up sequence |
| is_ddr | input | 1 | 1 = DDR device, 0 = SDR device |
| cl_half | input | 1 | 1 = CAS latency 2.5, 0 = CAS latency 2 |
| clk_mhz | input | MHZ_W | Clock frequency in MHz |
| ref_sel | input | 3 | Refresh period code |
| cmd | output | 3 | Command code |
| bank | output | 2 | Bank select for mode writes |
| addr | output | 13 | Address or mode word |
| busy | output | 1 | Sequence in progress |
| init_done | output | 1 | Sequence complete; periodic refresh may run |
| ref_interval | output | REF_W | Refresh interval value |

## Verification
Two situations are hard to reach from the ports. One is the long DLL settling wait, which would take tens of thousands of cycles at real clock rates; the stimulus sets a clock value of a few MHz to shorten it, and zero MHz to reach the floor at the minimum gap. The other is a start pulse during a run together with changed type, latency, frequency and refresh code. The stimulus injects these a fixed number of cycles into a DDR run and checks that the recorded command cycles, the mode words and the frozen refresh interval all match the undisturbed expectation.

// File: rtl/dinit_pkg.sv
`timescale 1ns/1ps
package dinit_pkg;

    localparam int ADDR_W = 13;
    localparam int BANK_W = 2;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PRE  = 3'd1,
        CMD_MODE = 3'd2,
        CMD_REF  = 3'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_LEAD, ST_PRE_EARLY, ST_EXT_MODE, ST_MODE_DLL,
        ST_PRE_MAIN, ST_REF_A, ST_REF_B, ST_MODE_RUN
    } step_e;

    typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_HOLD, PH_DONE} phase_e;

    typedef struct packed {
        cmd_e              op;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } dram_cmd_t;

    localparam logic [ADDR_W-1:0] A10_ALL = 13'h400;
    localparam logic [ADDR_W-1:0] DLL_RST = 13'h100;

    function automatic logic [16:0] period_ns(input logic [2:0] sel);
        case (sel)
            3'd0:    return 17'd15625;
            3'd1:    return 17'd3900;
            3'd2:    return 17'd7800;
            3'd3:    return 17'd31300;
            3'd4:    return 17'd62500;
            default: return 17'd125000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] mode_base(input logic cl_half);
        return {6'd0, (cl_half ? 3'b110 : 3'b010), 1'b0, 3'b011};
    endfunction

    function automatic step_e step_after(input step_e s);
        case (s)
            ST_LEAD:      return ST_PRE_MAIN;
            ST_PRE_EARLY: return ST_EXT_MODE;
            ST_EXT_MODE:  return ST_MODE_DLL;
            ST_MODE_DLL:  return ST_PRE_MAIN;
            ST_PRE_MAIN:  return ST_REF_A;
            ST_REF_A:     return ST_REF_B;
            default:      return ST_MODE_RUN;
        endcase
    endfunction

    function automatic logic long_gap(input step_e s);
        return (s == ST_LEAD) || (s == ST_MODE_DLL);
    endfunction

    function automatic dram_cmd_t cmd_for(input step_e s, input logic cl_half);
        dram_cmd_t c;
        c = '{op: CMD_NOP, bank: '0, addr: '0};
        case (s)
            ST_PRE_EARLY, ST_PRE_MAIN: begin c.op = CMD_PRE;  c.addr = A10_ALL; end
            ST_EXT_MODE:               begin c.op = CMD_MODE; c.bank = 2'd1;    end
            ST_MODE_DLL:               begin c.op = CMD_MODE; c.addr = mode_base(cl_half) | DLL_RST; end
            ST_REF_A, ST_REF_B:        c.op = CMD_REF;
            ST_MODE_RUN:               begin c.op = CMD_MODE; c.addr = mode_base(cl_half); end
            default:                   c.op = CMD_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dinit_refcalc.sv
`timescale 1ns/1ps
module dinit_refcalc import dinit_pkg::*; #(
    parameter int MHZ_W = 8,
    parameter int REF_W = 10
) (
    input  logic [2:0]       sel,
    input  logic [MHZ_W-1:0] mhz,
    output logic [REF_W-1:0] interval
);
    localparam int PROD_W = 17 + MHZ_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        prod     = PROD_W'(period_ns(sel)) * PROD_W'(mhz);
        quot     = prod / PROD_W'(64000);
        interval = (quot == '0) ? '0 : REF_W'(quot - PROD_W'(1));
    end
endmodule

// File: rtl/dinit_timer.sv
`timescale 1ns/1ps
module dinit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end

    assign zero = (cnt == '0);

    // R6: the hold window shrinks by exactly one per cycle
    assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/dinit_seq.sv
`timescale 1ns/1ps
module dinit_seq import dinit_pkg::*; #(
    parameter int MHZ_W   = 8,
    parameter int MIN_GAP = 4,
    parameter int REF_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_ddr,
    input  logic             cl_half,
    input  logic [MHZ_W-1:0] clk_mhz,
    input  logic [2:0]       ref_sel,
    output logic [2:0]       cmd,
    output logic [1:0]       bank,
    output logic [12:0]      addr,
    output logic             busy,
    output logic             init_done,
    output logic [REF_W-1:0] ref_interval
);
    localparam int CNT_W   = MHZ_W + 8;
    localparam int GAP_USE = (MIN_GAP < 2) ? 2 : MIN_GAP;

    logic             cfg_ddr, cfg_cl;
    logic [MHZ_W-1:0] cfg_mhz;
    logic [2:0]       cfg_sel;
    phase_e           phase;
    step_e            step;
    dram_cmd_t        cur, out;
    logic [CNT_W-1:0] wait_cyc, gap_len, load_val;
    logic             t_zero;

    assign busy      = (phase == PH_ISSUE) || (phase == PH_HOLD);
    assign init_done = (phase == PH_DONE);

    // configuration tracks inputs while idle or done, frozen during a run
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_ddr <= 1'b0;
            cfg_cl  <= 1'b0;
            cfg_mhz <= '0;
            cfg_sel <= '0;
        end else if (!busy) begin
            cfg_ddr <= is_ddr;
            cfg_cl  <= cl_half;
            cfg_mhz <= clk_mhz;
            cfg_sel <= ref_sel;
        end
    end

    always_comb begin
        wait_cyc = CNT_W'(cfg_mhz) * CNT_W'(200);
        if (long_gap(step) && wait_cyc > CNT_W'(GAP_USE)) gap_len = wait_cyc;
        else                                              gap_len = CNT_W'(GAP_USE);
        load_val = gap_len - CNT_W'(2);
    end

    dinit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (phase == PH_ISSUE),
        .load_val (load_val),
        .zero     (t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= ST_LEAD;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: if (start) begin
                    phase <= PH_ISSUE;
                    step  <= is_ddr ? ST_PRE_EARLY : ST_LEAD;
                end
                PH_ISSUE: begin
                    if (step == ST_MODE_RUN) phase <= PH_DONE;
                    else begin
                        phase <= PH_HOLD;
                        step  <= step_after(step);
                    end
                end
                default: if (t_zero) phase <= PH_ISSUE;
            endcase
        end
    end

    always_comb begin
        cur = cmd_for(step, cfg_cl);
        out = (phase == PH_ISSUE) ? cur : '{op: CMD_NOP, bank: '0, addr: '0};
    end

    assign cmd  = out.op;
    assign bank = out.bank;
    assign addr = out.addr;

    dinit_refcalc #(.MHZ_W(MHZ_W), .REF_W(REF_W)) u_refcalc (
        .sel      (cfg_sel),
        .mhz      (cfg_mhz),
        .interval (ref_interval)
    );

    assert_idle_nop_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cmd == CMD_NOP));
    assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && init_done));
    assert_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));
    assert_done_follows_mode_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> ($past(cmd) == CMD_MODE && $past(bank) == 2'd0 && !$past(addr[8])));
    assert_pre_all_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> addr[10]);
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({cfg_ddr, cfg_cl, cfg_mhz, cfg_sel}));
    assert_ref_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ref_interval));
endmodule

// File: tb/dinit_seq_bench.sv
`timescale 1ns/1ps
module dinit_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, is_ddr = 1'b0, cl_half = 1'b0;
    logic [7:0]  clk_mhz = '0;
    logic [2:0]  ref_sel = '0;
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [12:0] addr;
    logic        busy, init_done;
    logic [9:0]  ref_interval;

    int checks = 0, errors = 0;
    int n_got, done_cyc;
    int g_cyc [8];
    int g_cmd [8];
    int g_bank[8];
    int g_addr[8];
    int e_cyc [8];
    int e_cmd [8];
    int e_bank[8];
    int e_addr[8];

    always #2.5 clk = ~clk;

    dinit_seq u_dinit_seq (
        .clk(clk), .rst(rst), .start(start), .is_ddr(is_ddr), .cl_half(cl_half),
        .clk_mhz(clk_mhz), .ref_sel(ref_sel), .cmd(cmd), .bank(bank), .addr(addr),
        .busy(busy), .init_done(init_done), .ref_interval(ref_interval)
    );

    // {sel, mhz, expected interval}
    localparam logic [31:0] VEC [10] = '{
        {8'd0, 8'd100, 16'd23},  {8'd1, 8'd200, 16'd11}, {8'd2, 8'd133, 16'd15},
        {8'd3, 8'd50,  16'd23},  {8'd4, 8'd255, 16'd248}, {8'd5, 8'd255, 16'd497},
        {8'd6, 8'd128, 16'd249}, {8'd7, 8'd64,  16'd124}, {8'd1, 8'd10,  16'd0},
        {8'd5, 8'd1,   16'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic ddr, input logic cl, input logic [7:0] mhz,
                           input logic [2:0] sel, input bit disturb, input int frozen_exp);
        n_got = 0;
        done_cyc = 0;
        @(negedge clk);
        is_ddr = ddr; cl_half = cl; clk_mhz = mhz; ref_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 done cleared by start", int'(init_done), 0);
        chk("R7 busy after start", int'(busy), 1);
        for (int k = 1; k < 4000; k++) begin
            if (k > 1) @(negedge clk);
            if (cmd != 3'd0 && n_got < 8) begin
                g_cyc[n_got] = k; g_cmd[n_got] = int'(cmd);
                g_bank[n_got] = int'(bank); g_addr[n_got] = int'(addr);
                n_got++;
            end
            if (init_done && done_cyc == 0) done_cyc = k;
            if (disturb && k == 20) begin
                start = 1'b1; is_ddr = !ddr; cl_half = !cl; clk_mhz = 8'd1; ref_sel = 3'd0;
            end
            if (disturb && k == 21) start = 1'b0;
            if (disturb && k == 25) chk("R10 interval frozen while busy", int'(ref_interval), frozen_exp);
            if (init_done) break;
        end
    endtask

    task automatic cmp_seq(input string req, input int cnt, input int exp_done);
        chk({req, " command count"}, n_got, cnt);
        for (int i = 0; i < cnt; i++) begin
            chk({req, " command cycle"}, g_cyc[i], e_cyc[i]);
            chk({req, " command code"}, g_cmd[i], e_cmd[i]);
            chk({req, " bank"}, g_bank[i], e_bank[i]);
            chk({req, " addr"}, g_addr[i], e_addr[i]);
        end
        chk("R7 done cycle", done_cyc, exp_done);
    endtask

    task automatic set_e(input int i, input int c, input int op, input int b, input int a);
        e_cyc[i] = c; e_cmd[i] = op; e_bank[i] = b; e_addr[i] = a;
    endtask

    task automatic quiet_after_done();
        int bad;
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (cmd != 3'd0 || !init_done || busy) bad++;
        end
        chk("R7 NOP and done held after sequence", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset cmd NOP", int'(cmd), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset done", int'(init_done), 0);

        // R9 and R10: refresh interval table walk
        for (int v = 0; v < 10; v++) begin
            ref_sel = VEC[v][26:24];
            clk_mhz = VEC[v][23:16];
            @(negedge clk);
            @(negedge clk);
            chk($sformatf("R9 R10 interval vector %0d", v), int'(ref_interval), int'(VEC[v][15:0]));
        end

        // R2 R4 R5 R6 R8: DDR, CL 2.5, 4 MHz, busy start and input changes ignored
        run_seq(1'b1, 1'b1, 8'd4, 3'd5, 1'b1, 6);
        set_e(0, 1,   1, 0, 'h400);
        set_e(1, 5,   2, 1, 'h000);
        set_e(2, 9,   2, 0, 'h163);
        set_e(3, 809, 1, 0, 'h400);
        set_e(4, 813, 3, 0, 0);
        set_e(5, 817, 3, 0, 0);
        set_e(6, 821, 2, 0, 'h063);
        cmp_seq("R2 R4 R5 R6 R8 ddr", 7, 822);
        quiet_after_done();

        // R3 R4: SDR, CL 2, 3 MHz, started from the done state
        run_seq(1'b0, 1'b0, 8'd3, 3'd5, 1'b0, 0);
        set_e(0, 601, 1, 0, 'h400);
        set_e(1, 605, 3, 0, 0);
        set_e(2, 609, 3, 0, 0);
        set_e(3, 613, 2, 0, 'h023);
        cmp_seq("R3 R4 sdr", 4, 614);
        quiet_after_done();

        // R6 boundary: 0 MHz gives a settling wait at the minimum gap
        run_seq(1'b1, 1'b0, 8'd0, 3'd0, 1'b0, 0);
        set_e(0, 1,  1, 0, 'h400);
        set_e(1, 5,  2, 1, 'h000);
        set_e(2, 9,  2, 0, 'h123);
        set_e(3, 13, 1, 0, 'h400);
        set_e(4, 17, 3, 0, 0);
        set_e(5, 21, 3, 0, 0);
        set_e(6, 25, 2, 0, 'h023);
        cmp_seq("R6 R5 ddr zero wait", 7, 26);
        quiet_after_done();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule